// File: doc/BRIEF.md
# Byte-Addressed Descending Stack Pointer

This block holds the stack pointer of a small 8-bit processor core. The pointer counts bytes and the stack grows toward lower addresses. Software sees the pointer as two 8-bit I/O registers, a low half and a high half, and can read or write each one on its own. The core sequencer gives one adjust command per cycle. The block answers in the same cycle with the data-memory address of every stack byte that the command touches, plus read or write strobes. The pointer takes its new value on the next clock edge.

Single-byte data pushes and pops move the pointer by one. Return-address pushes and pops, used on calls, interrupt entry and returns, move it by two. A push stores at the current pointer and then decrements it. A pop increments the pointer first and then reads. For a return address, the low byte sits at the higher address of the pair. Software must load the pointer with a value above 0x60 before the first call or interrupt. The block does not enforce this. Arithmetic wraps modulo 2^16 and the block reports no error.

Top module: `sp_stack_ptr`

## Requirements
- R1: After reset both pointer halves read 0, and with command code 0 both strobes are low.
- R2: A low-half I/O write loads the write data into pointer bits 7:0 at the next edge and leaves bits 15:8 unchanged.
- R3: A high-half I/O write loads the write data into pointer bits 15:8 at the next edge and leaves bits 7:0 unchanged.
- R4: Command code 1 (byte push) raises the write strobe with word flag low and both address outputs equal to the pointer P. The pointer becomes P-1.
- R5: Command code 2 (byte pop) raises the read strobe with word flag low and both address outputs equal to P+1. The pointer becomes P+1.
- R6: Command code 3 (return-address push) raises the write strobe and the word flag. The low-byte address is P and the high-byte address is P-1. The pointer becomes P-2.
- R7: Command code 4 (return-address pop) raises the read strobe and the word flag. The high-byte address is P+1 and the low-byte address is P+2. The pointer becomes P+2.
- R8: When either I/O write is active, the command is discarded: both strobes stay low and only the written half changes.
- R9: Address outputs and the pointer wrap modulo 2^16 on underflow and overflow, with no error indication.
- R10: Command codes 0, 5, 6 and 7 raise no strobe and leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr_lo_i | input | 1 | Software write to pointer low half |
| io_wr_hi_i | input | 1 | Software write to pointer high half |
| io_wdata_i | input | 8 | Software write data |
| cmd_i | input | 3 | Adjust command code from the core |
| sp_lo_o | output | 8 | Pointer low half, read by software |
| sp_hi_o | output | 8 | Pointer high half, read by software |
| acc_wr_o | output | 1 | Stack write access this cycle |
| acc_rd_o | output | 1 | Stack read access this cycle |
| acc_word_o | output | 1 | Access covers two bytes (return address) |
| addr_lo_o | output | 16 | Address of the single byte, or of the low return-address byte |
| addr_hi_o | output | 16 | Address of the high return-address byte; equals addr_lo_o for single bytes |

## Verification
The assertions assume that reset is released away from a clock edge. They also assume that command and I/O write inputs change only between edges, so every cycle shows one stable command. The bench drives all inputs on the falling edge and holds them idle while reset is active. It then issues one scoreboard item per cycle, each pairing a command or software write with the pointer expected before the edge. It also exercises overlap of I/O writes with commands, the unused codes, and pointer values close to 0x0000 and 0xFFFF, so that the wrap cases occur.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_PUSH_B = 3'd1,
        CMD_POP_B  = 3'd2,
        CMD_PUSH_W = 3'd3,
        CMD_POP_W  = 3'd4
    } sp_cmd_e;

    localparam int CMD_W = 3;

endpackage

// File: rtl/sp_cmd_decode.sv
module sp_cmd_decode
    import sp_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             sw_wr_i,
    output logic             take_o,
    output logic             push_o,
    output logic             word_o
);
    logic valid;

    always_comb begin
        valid  = 1'b0;
        push_o = 1'b0;
        word_o = 1'b0;
        case (cmd_i)
            CMD_PUSH_B: begin valid = 1'b1; push_o = 1'b1; end
            CMD_POP_B:  begin valid = 1'b1; end
            CMD_PUSH_W: begin valid = 1'b1; push_o = 1'b1; word_o = 1'b1; end
            CMD_POP_W:  begin valid = 1'b1; word_o = 1'b1; end
            default:    begin valid = 1'b0; end
        endcase
        // a software write in the same cycle overrides any adjust (R8)
        take_o = valid && !sw_wr_i;
    end
endmodule

// File: rtl/sp_addr_gen.sv
module sp_addr_gen #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] sp_i,
    input  logic              push_i,
    input  logic              word_i,
    output logic [ADDR_W-1:0] addr_lo_o,
    output logic [ADDR_W-1:0] addr_hi_o,
    output logic [ADDR_W-1:0] sp_next_o
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] sp_m1;
    logic [ADDR_W-1:0] sp_p1;
    logic [ADDR_W-1:0] sp_p2;

    always_comb begin
        step  = word_i ? TWO : ONE;
        sp_m1 = sp_i - ONE;
        sp_p1 = sp_i + ONE;
        sp_p2 = sp_i + TWO;
        if (push_i) begin
            // store at pointer, then move down; high return byte goes below
            addr_lo_o = sp_i;
            addr_hi_o = word_i ? sp_m1 : sp_i;
            sp_next_o = sp_i - step;
        end else begin
            // move up first, then read; high return byte comes back first
            addr_hi_o = sp_p1;
            addr_lo_o = word_i ? sp_p2 : sp_p1;
            sp_next_o = sp_i + step;
        end
    end
endmodule

// File: rtl/sp_stack_ptr.sv
module sp_stack_ptr
    import sp_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr_lo_i,
    input  logic              io_wr_hi_i,
    input  logic [BYTE_W-1:0] io_wdata_i,
    input  logic [CMD_W-1:0]  cmd_i,
    output logic [BYTE_W-1:0] sp_lo_o,
    output logic [BYTE_W-1:0] sp_hi_o,
    output logic              acc_wr_o,
    output logic              acc_rd_o,
    output logic              acc_word_o,
    output logic [ADDR_W-1:0] addr_lo_o,
    output logic [ADDR_W-1:0] addr_hi_o
);
    localparam int HI_W = ADDR_W - BYTE_W;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [BYTE_W-1:0] lo;
    } sp_state_t;

    sp_state_t         st_d, st_q;
    logic              sw_wr;
    logic              take;
    logic              is_push;
    logic              is_word;
    logic [ADDR_W-1:0] sp_cur;
    logic [ADDR_W-1:0] sp_adj;

    assign sw_wr  = io_wr_lo_i || io_wr_hi_i;
    assign sp_cur = {st_q.hi, st_q.lo};

    sp_cmd_decode u_dec (
        .cmd_i   (cmd_i),
        .sw_wr_i (sw_wr),
        .take_o  (take),
        .push_o  (is_push),
        .word_o  (is_word)
    );

    sp_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .sp_i      (sp_cur),
        .push_i    (is_push),
        .word_i    (is_word),
        .addr_lo_o (addr_lo_o),
        .addr_hi_o (addr_hi_o),
        .sp_next_o (sp_adj)
    );

    always_comb begin
        st_d = st_q;
        if (sw_wr) begin
            if (io_wr_lo_i) st_d.lo = io_wdata_i;
            if (io_wr_hi_i) st_d.hi = HI_W'(io_wdata_i);
        end else if (take) begin
            st_d = sp_state_t'(sp_adj);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sp_lo_o    = st_q.lo;
    assign sp_hi_o    = BYTE_W'(st_q.hi);
    assign acc_wr_o   = take && is_push;
    assign acc_rd_o   = take && !is_push;
    assign acc_word_o = take && is_word;

    AST_PUSH_B_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && cmd_i == CMD_PUSH_B) |=> sp_cur == ADDR_W'($past(sp_cur) - 1'b1)); // R4
    AST_POP_B_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && cmd_i == CMD_POP_B) |=> sp_cur == ADDR_W'($past(sp_cur) + 1'b1)); // R5
    AST_PUSH_W_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr_o && acc_word_o) |-> addr_lo_o == ADDR_W'(addr_hi_o + 1'b1)); // R6
    AST_POP_W_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && cmd_i == CMD_POP_W) |=> sp_cur == ADDR_W'($past(sp_cur) + 2'd2)); // R7
    AST_SW_LO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr_lo_i |=> sp_lo_o == $past(io_wdata_i)); // R8
    AST_SW_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |-> !acc_wr_o && !acc_rd_o); // R8
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_wr_o, acc_rd_o})); // R4
    AST_UNUSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && (cmd_i == CMD_NONE || cmd_i > CMD_POP_W)) |=> $stable(sp_cur)); // R10
endmodule

// File: tb/sp_stack_ptr_bench.sv
module sp_stack_ptr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr_lo = 1'b0, io_wr_hi = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [2:0]  cmd = 3'd0;
    logic [7:0]  sp_lo, sp_hi;
    logic        acc_wr, acc_rd, acc_word;
    logic [15:0] addr_lo, addr_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [15:0] sp;
        logic        wr, rd, word;
        logic [15:0] alo, ahi;
    } exp_t;
    exp_t sb[$];
    logic [15:0] model_sp = 16'h0000;

    always #10 clk = ~clk;

    sp_stack_ptr u_sp_stack_ptr (
        .clk(clk), .rst_n(rst_n),
        .io_wr_lo_i(io_wr_lo), .io_wr_hi_i(io_wr_hi), .io_wdata_i(io_wdata),
        .cmd_i(cmd), .sp_lo_o(sp_lo), .sp_hi_o(sp_hi),
        .acc_wr_o(acc_wr), .acc_rd_o(acc_rd), .acc_word_o(acc_word),
        .addr_lo_o(addr_lo), .addr_hi_o(addr_hi)
    );

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected result pushed to the scoreboard
    task automatic step(string tag, logic wlo, logic whi, logic [7:0] wd, logic [2:0] c);
        exp_t e;
        @(negedge clk);
        io_wr_lo = wlo; io_wr_hi = whi; io_wdata = wd; cmd = c;
        e.tag = tag; e.sp = model_sp;
        e.wr = 1'b0; e.rd = 1'b0; e.word = 1'b0; e.alo = 16'h0; e.ahi = 16'h0;
        if (wlo || whi) begin
            if (wlo) model_sp[7:0]  = wd;
            if (whi) model_sp[15:8] = wd;
        end else begin
            case (c)
                3'd1: begin e.wr = 1; e.alo = model_sp; e.ahi = model_sp; model_sp = model_sp - 16'd1; end
                3'd2: begin e.rd = 1; e.alo = model_sp + 16'd1; e.ahi = model_sp + 16'd1; model_sp = model_sp + 16'd1; end
                3'd3: begin e.wr = 1; e.word = 1; e.alo = model_sp; e.ahi = model_sp - 16'd1; model_sp = model_sp - 16'd2; end
                3'd4: begin e.rd = 1; e.word = 1; e.ahi = model_sp + 16'd1; e.alo = model_sp + 16'd2; model_sp = model_sp + 16'd2; end
                default: ;
            endcase
        end
        sb.push_back(e);
    endtask

    // monitor: compares outputs in the middle of the low clock phase
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "sp", {sp_hi, sp_lo}, e.sp);
                chk(e.tag, "wr", 16'(acc_wr), 16'(e.wr));
                chk(e.tag, "rd", 16'(acc_rd), 16'(e.rd));
                chk(e.tag, "word", 16'(acc_word), 16'(e.word));
                if (e.wr || e.rd) begin
                    chk(e.tag, "addr_lo", addr_lo, e.alo);
                    chk(e.tag, "addr_hi", addr_hi, e.ahi);
                end
            end
        end
    end

    initial begin
        #5000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1", 0, 0, 8'h00, 3'd0);
        step("R2", 1, 0, 8'hF0, 3'd0);
        step("R3", 0, 1, 8'h10, 3'd0);
        step("R2", 0, 0, 8'h00, 3'd0);
        step("R4", 0, 0, 8'h00, 3'd1);
        step("R4", 0, 0, 8'h00, 3'd1);
        step("R5", 0, 0, 8'h00, 3'd2);
        step("R6", 0, 0, 8'h00, 3'd3);
        step("R7", 0, 0, 8'h00, 3'd4);
        step("R6", 0, 0, 8'h00, 3'd3);
        step("R8", 1, 0, 8'h80, 3'd3);
        step("R8", 0, 1, 8'h22, 3'd2);
        step("R8", 1, 1, 8'h33, 3'd1);
        step("R10", 0, 0, 8'h00, 3'd5);
        step("R10", 0, 0, 8'h00, 3'd6);
        step("R10", 0, 0, 8'h00, 3'd7);
        step("R10", 0, 0, 8'h00, 3'd0);
        step("R9", 1, 1, 8'h00, 3'd0);
        step("R9", 0, 0, 8'h00, 3'd1);
        step("R9", 0, 0, 8'h00, 3'd2);
        step("R9", 1, 1, 8'h01, 3'd0);
        step("R9", 1, 0, 8'h00, 3'd0);
        step("R9", 0, 0, 8'h00, 3'd3);
        step("R9", 0, 0, 8'h00, 3'd4);
        step("R9", 0, 1, 8'hFF, 3'd0);
        step("R9", 1, 0, 8'hFF, 3'd0);
        step("R9", 0, 0, 8'h00, 3'd4);
        step("R9", 0, 0, 8'h00, 3'd3);
        step("R9", 0, 0, 8'h00, 3'd0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule